// File: doc/BRIEF.md
# Planar Tile Row Pixel Fetcher

This block turns a request for one row of one 8x8 tile into eight 2-bit colour indices, one per clock, leftmost pixel first. The tile's shape is held in an external pattern memory with synchronous reads. Each tile takes 16 bytes there: the first eight bytes hold bit 0 of every pixel, one byte per row, and the last eight hold bit 1 for the same rows. One row therefore costs two memory reads 8 bytes apart. The block forms both addresses, issues the two reads back to back, and joins the two plane bytes into pixels as it shifts them out.

A request carries a tile number, a half-table select, a 4-bit row number and a tall-sprite mode flag. In normal mode only the low three row bits count. In tall (8x16) mode the tile number's bit 0 picks the half, and row bit 3 picks the upper or lower tile of an even/odd pair. Requests use a valid/ready handshake. Pixels come out with a valid flag, a transparency flag and a pulse that marks the last pixel of the row. Palette, attribute and priority handling are left to the logic downstream.

Top module: `tile_row_fetcher`

## Requirements
- R1: In normal mode (req_tall=0) the 13-bit read address is {half, tile[7:0], plane, row[2:0]}, with half at bit 12, plane at bit 3 and the fine row in bits 2:0; req_row[3] has no effect.
- R2: In tall mode (req_tall=1) req_half is ignored. Address bit 12 is tile[0], bits 11:4 are {tile[7:1], row[3]}, bit 3 is the plane and bits 2:0 are row[2:0].
- R3: In the cycle after a request is accepted, mem_rd is high with the plane-0 address. In the next cycle mem_rd is high with the plane-1 address, which is the same address with bit 3 set. mem_rd is low at every other time.
- R4: Each emitted index has bit 0 taken from the plane-0 byte and bit 1 taken from the matching bit of the plane-1 byte.
- R5: Pixels are emitted on eight consecutive cycles, most significant bit of each plane byte first. The first pixel is valid in the fourth cycle after the accepting clock edge.
- R6: pix_transparent is high exactly when pix_valid is high and pix_index is 0.
- R7: req_ready is low from the acceptance of a request until the cycle of the eighth pixel, when it is high again. A request presented in that cycle is accepted, and its plane-0 read follows in the next cycle.
- R8: row_done is high for exactly one cycle per row, in the cycle of the eighth pixel.
- R9: After a synchronous active-high reset the block is idle: req_ready is high, while pix_valid, mem_rd, row_done and pix_transparent are low.
- R10: A request presented while req_ready is low is ignored and does not change the row being fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_tile | input | 8 | Tile number |
| req_half | input | 1 | Pattern half select (normal mode) |
| req_row | input | 4 | Row within tile; bit 3 used only in tall mode |
| req_tall | input | 1 | Tall 8x16 sprite addressing |
| mem_rd | output | 1 | Pattern memory read strobe |
| mem_addr | output | 13 | Pattern memory address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| pix_valid | output | 1 | Pixel output valid |
| pix_index | output | 2 | Colour index of current pixel |
| pix_transparent | output | 1 | Current pixel index is 0 |
| row_done | output | 1 | Last pixel of the row |

## Verification
Counting from the clock edge that accepts a request, the plane-0 address is due in the first cycle after it, the plane-1 address in the second, nothing in the third, and the eight pixels in the fourth through the eleventh. row_done and the return of req_ready fall in the eleventh. The bench drives inputs and samples outputs on falling edges and walks those cycles one by one, so each check lands in the exact cycle its result is due. Back-to-back rows are started in the falling-edge window of the eighth pixel, and the bench then expects the next plane-0 read one cycle later.

// File: rtl/tile_fetch_pkg.sv
package tile_fetch_pkg;

    localparam int TILE_W = 8;               // tile number width
    localparam int FROW_W = 3;               // fine row width (8 rows)
    localparam int PIX_N  = 1 << FROW_W;     // pixels per row = bits per plane byte
    localparam int PLANES = 2;               // bit planes per pixel
    localparam int ADDR_W = 1 + TILE_W + 1 + FROW_W;

    typedef logic [PLANES-1:0] pix_t;

    typedef struct packed {
        logic [TILE_W-1:0] tile;
        logic              half;
        logic [FROW_W:0]   row;
        logic              tall;
    } row_req_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_LO,
        SQ_RD_HI,
        SQ_CAPT,
        SQ_EMIT
    } seq_state_e;

endpackage

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tile_fetch_pkg::*;
#(
    parameter int TW = TILE_W,
    parameter int RW = FROW_W,
    localparam int AW = 1 + TW + 1 + RW
) (
    input  logic [TW-1:0] tile,
    input  logic          half,
    input  logic [RW:0]   row,
    input  logic          tall,
    input  logic          plane,
    output logic [AW-1:0] addr
);

    logic          eff_half;
    logic [TW-1:0] eff_tile;

    always_comb begin
        if (tall) begin
            // pair of tiles: bit 0 of the number picks the half, row MSB picks the tile
            eff_half = tile[0];
            eff_tile = {tile[TW-1:1], row[RW]};
        end else begin
            eff_half = half;
            eff_tile = tile;
        end
        addr = {eff_half, eff_tile, plane, row[RW-1:0]};
    end

endmodule

// File: rtl/tile_seq.sv
module tile_seq
    import tile_fetch_pkg::*;
#(
    parameter int NPIX = PIX_N,
    localparam int CW  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic rd_en,
    output logic rd_plane,
    output logic cap_lo,
    output logic load,
    output logic emit,
    output logic last
);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        last      = (state_q == SQ_EMIT) && (cnt_q == CW'(NPIX - 1));
        req_ready = (state_q == SQ_IDLE) || last;
        accept    = req_valid && req_ready;
        rd_en     = (state_q == SQ_RD_LO) || (state_q == SQ_RD_HI);
        rd_plane  = (state_q == SQ_RD_HI);
        cap_lo    = (state_q == SQ_RD_HI);   // plane-0 byte is on the data bus now
        load      = (state_q == SQ_CAPT);    // plane-1 byte is on the data bus now
        emit      = (state_q == SQ_EMIT);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQ_IDLE:  if (accept) state_d = SQ_RD_LO;
            SQ_RD_LO: state_d = SQ_RD_HI;
            SQ_RD_HI: state_d = SQ_CAPT;
            SQ_CAPT: begin
                state_d = SQ_EMIT;
                cnt_d   = '0;
            end
            SQ_EMIT: begin
                if (last) state_d = accept ? SQ_RD_LO : SQ_IDLE;
                else      cnt_d   = cnt_q + 1'b1;
            end
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/plane_shifter.sv
module plane_shifter
    import tile_fetch_pkg::*;
#(
    parameter int NPIX = PIX_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_lo,
    input  logic            load,
    input  logic            shift,
    input  logic [NPIX-1:0] rdata,
    output pix_t            pix
);

    logic [NPIX-1:0] stage_q;              // holds plane 0 until plane 1 arrives

    always_ff @(posedge clk) begin
        if (rst)         stage_q <= '0;
        else if (cap_lo) stage_q <= rdata;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [NPIX-1:0] sh_q;
        logic [NPIX-1:0] src;

        if (p == PLANES - 1) begin : g_direct
            assign src = rdata;
        end else begin : g_staged
            assign src = stage_q;
        end

        always_ff @(posedge clk) begin
            if (rst)        sh_q <= '0;
            else if (load)  sh_q <= src;
            else if (shift) sh_q <= {sh_q[NPIX-2:0], 1'b0};
        end

        assign pix[p] = sh_q[NPIX-1];      // leftmost pixel leaves first
    end

endmodule

// File: rtl/tile_row_fetcher.sv
module tile_row_fetcher
    import tile_fetch_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [TILE_W-1:0]   req_tile,
    input  logic                req_half,
    input  logic [FROW_W:0]     req_row,
    input  logic                req_tall,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [PIX_N-1:0]    mem_rdata,
    output logic                pix_valid,
    output logic [PLANES-1:0]   pix_index,
    output logic                pix_transparent,
    output logic                row_done
);

    row_req_t cur_q;
    logic     accept, rd_plane, cap_lo, load, emit, last;
    pix_t     pix;

    tile_seq #(.NPIX(PIX_N)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .rd_en     (mem_rd),
        .rd_plane  (rd_plane),
        .cap_lo    (cap_lo),
        .load      (load),
        .emit      (emit),
        .last      (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (accept) begin
            cur_q.tile <= req_tile;
            cur_q.half <= req_half;
            cur_q.row  <= req_row;
            cur_q.tall <= req_tall;
        end
    end

    tile_addr_gen #(.TW(TILE_W), .RW(FROW_W)) u_addr (
        .tile  (cur_q.tile),
        .half  (cur_q.half),
        .row   (cur_q.row),
        .tall  (cur_q.tall),
        .plane (rd_plane),
        .addr  (mem_addr)
    );

    plane_shifter #(.NPIX(PIX_N)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .cap_lo (cap_lo),
        .load   (load),
        .shift  (emit),
        .rdata  (mem_rdata),
        .pix    (pix)
    );

    assign pix_valid       = emit;
    assign pix_index       = emit ? pix : '0;
    assign pix_transparent = emit && (pix == '0);
    assign row_done        = last;

endmodule

// File: rtl/tile_row_fetcher_chk.sv
module tile_row_fetcher_chk
    import tile_fetch_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic [TILE_W-1:0]   req_tile,
    input logic                req_half,
    input logic [FROW_W:0]     req_row,
    input logic                req_tall,
    input logic                mem_rd,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                pix_valid,
    input logic [PLANES-1:0]   pix_index,
    input logic                pix_transparent,
    input logic                row_done
);

    logic acc;
    assign acc = req_valid && req_ready;

    p_addr_normal_r1: assert property (@(posedge clk) disable iff (rst)
        acc && !req_tall |=> mem_addr == {$past(req_half), $past(req_tile), 1'b0,
                                          $past(req_row[FROW_W-1:0])});

    p_addr_tall_r2: assert property (@(posedge clk) disable iff (rst)
        acc && req_tall |=> mem_addr == {$past(req_tile[0]), $past(req_tile[TILE_W-1:1]),
                                         $past(req_row[FROW_W]), 1'b0,
                                         $past(req_row[FROW_W-1:0])});

    p_read_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
        acc |=> mem_rd);

    p_plane_step_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd && $past(mem_rd) |-> mem_addr == ($past(mem_addr) | ADDR_W'(8)));

    p_read_pair_ends_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd && $past(mem_rd) |=> !mem_rd);

    p_transparent_r6: assert property (@(posedge clk) disable iff (rst)
        pix_transparent == (pix_valid && pix_index == '0));

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        acc |=> !req_ready);

    p_done_on_last_r8: assert property (@(posedge clk) disable iff (rst)
        row_done |-> pix_valid && req_ready);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        row_done |=> !row_done);

    p_no_read_while_emit_r3: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> !mem_rd);

endmodule

bind tile_row_fetcher tile_row_fetcher_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_tile        (req_tile),
    .req_half        (req_half),
    .req_row         (req_row),
    .req_tall        (req_tall),
    .mem_rd          (mem_rd),
    .mem_addr        (mem_addr),
    .pix_valid       (pix_valid),
    .pix_index       (pix_index),
    .pix_transparent (pix_transparent),
    .row_done        (row_done)
);

// File: tb/tile_row_fetcher_test.sv
`timescale 1ns/1ps
module tile_row_fetcher_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [7:0]  req_tile;
    logic        req_half;
    logic [3:0]  req_row;
    logic        req_tall;
    logic        mem_rd;
    logic [12:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        pix_valid;
    logic [1:0]  pix_index;
    logic        pix_transparent;
    logic        row_done;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tile_row_fetcher uut (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_tile        (req_tile),
        .req_half        (req_half),
        .req_row         (req_row),
        .req_tall        (req_tall),
        .mem_rd          (mem_rd),
        .mem_addr        (mem_addr),
        .mem_rdata       (mem_rdata),
        .pix_valid       (pix_valid),
        .pix_index       (pix_index),
        .pix_transparent (pix_transparent),
        .row_done        (row_done)
    );

    // pattern memory model: computed contents, one-cycle read latency
    function automatic logic [7:0] pat_byte(logic [12:0] a);
        if (a == 13'h0691) return 8'hF0;
        if (a == 13'h0699) return 8'h3C;
        return (a[7:0] * 8'd29) ^ {a[12:8], 3'b101};
    endfunction

    always_ff @(posedge clk) mem_rdata <= pat_byte(mem_addr);

    function automatic logic [12:0] exp_addr(logic [7:0] t, logic h, logic [3:0] r,
                                             logic tall, logic plane);
        if (tall) return {t[0], t[7:1], r[3], plane, r[2:0]};
        return {h, t, plane, r[2:0]};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // call at a falling edge with the block ready; returns at the falling edge after acceptance
    task automatic issue(logic [7:0] t, logic h, logic [3:0] r, logic tall);
        req_tile  = t;
        req_half  = h;
        req_row   = r;
        req_tall  = tall;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // call at the falling edge after acceptance; returns at the falling edge of the eighth pixel
    task automatic check_row(logic [7:0] t, logic h, logic [3:0] r, logic tall,
                             string areq, bit noise);
        logic [12:0] a0, a1;
        logic [7:0]  lo, hi;
        a0 = exp_addr(t, h, r, tall, 1'b0);
        a1 = exp_addr(t, h, r, tall, 1'b1);
        lo = pat_byte(a0);
        hi = pat_byte(a1);
        chk(mem_rd == 1'b1, "R3", "plane0 read strobe", int'(mem_rd), 1);
        chk(mem_addr == a0, areq, "plane0 address", int'(mem_addr), int'(a0));
        chk(req_ready == 1'b0, "R7", "ready while reading", int'(req_ready), 0);
        if (noise) begin
            // R10: a competing request while busy
            req_tile  = ~t;
            req_half  = ~h;
            req_row   = ~r;
            req_tall  = ~tall;
            req_valid = 1'b1;
        end
        @(negedge clk);
        chk(mem_rd == 1'b1, "R3", "plane1 read strobe", int'(mem_rd), 1);
        chk(mem_addr == a1, "R3", "plane1 address", int'(mem_addr), int'(a1));
        @(negedge clk);
        chk(mem_rd == 1'b0 && pix_valid == 1'b0, "R5", "gap cycle idle",
            int'({mem_rd, pix_valid}), 0);
        for (int k = 0; k < 8; k++) begin
            logic [1:0] e;
            @(negedge clk);
            e = {hi[7-k], lo[7-k]};
            chk(pix_valid == 1'b1, "R5", "pixel valid", int'(pix_valid), 1);
            chk(pix_index == e, noise ? "R10" : "R4", "pixel index", int'(pix_index), int'(e));
            chk(pix_transparent == (e == 2'd0), "R6", "transparency", int'(pix_transparent),
                int'(e == 2'd0));
            chk(row_done == (k == 7), "R8", "row done", int'(row_done), int'(k == 7));
            chk(req_ready == (k == 7), "R7", "ready during emit", int'(req_ready), int'(k == 7));
            if (noise && k == 6) req_valid = 1'b0;
        end
    endtask

    task automatic expect_idle(string req);
        @(negedge clk);
        chk(pix_valid == 1'b0 && mem_rd == 1'b0 && row_done == 1'b0, req, "idle after row",
            int'({pix_valid, mem_rd, row_done}), 0);
        chk(req_ready == 1'b1, req, "ready when idle", int'(req_ready), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req_valid = 1'b0; req_tile = '0; req_half = 1'b0; req_row = '0; req_tall = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "reset ready", int'(req_ready), 1);
        chk({pix_valid, mem_rd, row_done, pix_transparent} == 4'b0, "R9", "reset outputs",
            int'({pix_valid, mem_rd, row_done, pix_transparent}), 0);
    endtask

    task automatic t_known_row();
        // row 1 of tile 0x69, lower half: 0x0691 / 0x0699, pixels 1,1,3,3,2,2,0,0
        issue(8'h69, 1'b0, 4'd1, 1'b0);
        check_row(8'h69, 1'b0, 4'd1, 1'b0, "R1", 1'b0);
        expect_idle("R9");
    endtask

    task automatic t_upper_half();
        issue(8'hC3, 1'b1, 4'd6, 1'b0);
        check_row(8'hC3, 1'b1, 4'd6, 1'b0, "R1", 1'b0);
        expect_idle("R7");
    endtask

    task automatic t_row_msb_ignored();
        // R1: row bit 3 set in normal mode reads fine row 3
        issue(8'h2E, 1'b0, 4'b1011, 1'b0);
        check_row(8'h2E, 1'b0, 4'b0011, 1'b0, "R1", 1'b0);
        expect_idle("R1");
    endtask

    task automatic t_tall_pair();
        // R2: tile 0x6B, half input ignored; row 9 -> tile 0x6B upper half, row 2 -> tile 0x6A
        issue(8'h6B, 1'b0, 4'd9, 1'b1);
        check_row(8'h6B, 1'b0, 4'd9, 1'b1, "R2", 1'b0);
        expect_idle("R2");
        issue(8'h6B, 1'b0, 4'd2, 1'b1);
        check_row(8'h6B, 1'b0, 4'd2, 1'b1, "R2", 1'b0);
        expect_idle("R2");
        issue(8'h14, 1'b1, 4'd15, 1'b1);
        check_row(8'h14, 1'b1, 4'd15, 1'b1, "R2", 1'b0);
        expect_idle("R2");
    endtask

    task automatic t_busy_ignored();
        issue(8'h5A, 1'b1, 4'd4, 1'b0);
        check_row(8'h5A, 1'b1, 4'd4, 1'b0, "R10", 1'b1);
        expect_idle("R10");
    endtask

    task automatic t_back_to_back();
        // R7: next request offered in the eighth-pixel cycle
        issue(8'h07, 1'b0, 4'd0, 1'b0);
        check_row(8'h07, 1'b0, 4'd0, 1'b0, "R7", 1'b0);
        issue(8'hF8, 1'b1, 4'd7, 1'b0);
        check_row(8'hF8, 1'b1, 4'd7, 1'b0, "R7", 1'b0);
        issue(8'h69, 1'b0, 4'd1, 1'b0);
        check_row(8'h69, 1'b0, 4'd1, 1'b0, "R7", 1'b0);
        expect_idle("R7");
    endtask

    initial begin
        t_reset();
        t_known_row();
        t_upper_half();
        t_row_msb_ignored();
        t_tall_pair();
        t_busy_ignored();
        t_back_to_back();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule